// File: doc/BRIEF.md
# Multi-lane aligned release buffer

This block sits on the receive side of a multi-lane serial link after the lanes have been decoded. Each lane's frames arrive at their own time, because the lanes differ in trace and transceiver delay. Each lane stores its frames in its own FIFO, starting with the frame that carries the lane's start marker. All lanes are then read out together, one frame per frame tick, so that the frame at the head of every lane leaves in the same cycle.

The common read-out instant does not depend on when data happens to arrive. It is tied to the local multiframe clock edge, shifted by a programmable number of frame periods. Because of this, the latency through the link is the same after every startup. A small setting releases early and gives low latency. A larger setting moves the release instant away from the zone of uncertain arrival. If a lane is still silent when a release instant comes, that lane is flagged and the release waits for the next instant.

A resync request empties every FIFO and clears the status, and the alignment then starts over.

Top module: `lane_release_buffer`

## Requirements
- R1: After reset, and in the cycle after a resync request, out_vld is 0, out_data is 0, lane_late and lane_slip are 0, and every lane FIFO is empty.
- R2: A lane stores nothing until a cycle with lane_vld and lane_start both high for that lane. That frame and every later frame with lane_vld high are stored in order. Valid frames before the start marker are discarded.
- R3: A frame tick is a release point when the number of frame ticks since the last tick with mf_edge high equals rbd. The tick that carries mf_edge has index 0, which stands for rbd equal to the frames per multiframe (8 by default).
- R4: An rbd of 0, or an rbd greater than the frames per multiframe, behaves exactly as rbd equal to the frames per multiframe.
- R5: Read-out begins at the first release point at which every lane stored its first frame in an earlier cycle. Until then out_vld stays 0.
- R6: At a release point where at least one lane, but not every lane, has stored its first frame, each lane without data sets its bit in lane_late. The bit then stays set until resync. Release points reached before any lane has data set no flag.
- R7: From the release tick on, every frame tick pops one frame from every lane in lockstep. The popped frames appear in out_data, with lane l at bits [l*DATA_W +: DATA_W], one cycle after the tick, and out_vld is high for that one cycle.
- R8: A cycle with frame_tick low pops nothing. out_vld is 0 in the following cycle and out_data keeps its value.
- R9: A lane sets its sticky bit in lane_slip when a frame arrives while its FIFO is full and is not being read (the frame is dropped). It also sets the bit when a pop hits an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| resync | input | 1 | Synchronous request to empty all lanes and clear status |
| frame_tick | input | 1 | One-cycle pulse per frame period |
| mf_edge | input | 1 | Multiframe clock edge, high on the frame tick that starts a multiframe |
| rbd | input | RBD_W | Release delay in frame periods, legal range 1 to FRAMES_PER_MF |
| lane_vld | input | LANES | Per-lane frame valid |
| lane_start | input | LANES | Per-lane marker for the first frame to keep |
| lane_data | input | LANES*DATA_W | Per-lane frame data, lane l at bits [l*DATA_W +: DATA_W] |
| out_vld | output | 1 | Aligned frame valid |
| out_data | output | LANES*DATA_W | Aligned frame data of all lanes |
| lane_late | output | LANES | Sticky per-lane flag: lane silent at a release point |
| lane_slip | output | LANES | Sticky per-lane flag: FIFO overflow or read on empty |

## Verification
The release rule is driven with several lane arrival patterns. In the first, the lanes are staggered but all are present before the first release point. In the second, the last lane arrives exactly one frame before the release point. In the third, the last lane arrives on the release point itself. In the fourth, lanes arrive after an early release point. The exact cycle of the first valid output, together with the late mask, separates an off-by-one in the arrival test from an off-by-one in the frame index. Settings of 1, of the full multiframe, of 0 and of a value past the multiframe show whether the release point follows the edge shift and the out-of-range rule. Gaps in the frame tick, a lane that never arrives and lanes that stop sending separate lockstep pacing from overflow and underrun.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

   typedef enum logic {
      RLS_WAIT = 1'b0,
      RLS_RUN  = 1'b1
   } rls_state_e;

endpackage

// File: rtl/lrb_mf_timer.sv
// Frame index inside the multiframe and release-point detection.
module lrb_mf_timer #(
   parameter int FRAMES_PER_MF = 8,
   parameter int RBD_W         = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_tick,
   input  logic             mf_edge,
   input  logic [RBD_W-1:0] rbd,
   output logic             rls_point
);
   localparam int IDX_W = (FRAMES_PER_MF < 2) ? 1 : $clog2(FRAMES_PER_MF);

   logic [IDX_W-1:0] pos_q;
   logic [IDX_W-1:0] cur_idx;
   logic [IDX_W-1:0] tgt_idx;

   // Index of the current tick: the edge tick is 0, later ticks count up.
   always_comb begin
      cur_idx = mf_edge ? '0 : pos_q + IDX_W'(1);
   end

   // Out-of-range settings fold onto the edge itself.
   always_comb begin
      if ((rbd == '0) || (rbd >= RBD_W'(FRAMES_PER_MF))) begin
         tgt_idx = '0;
      end else begin
         tgt_idx = IDX_W'(rbd);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (frame_tick) begin
         pos_q <= cur_idx;
      end
   end

   assign rls_point = frame_tick && (cur_idx == tgt_idx);

endmodule

// File: rtl/lrb_lane_fifo.sv
// One lane: capture from start marker, elastic storage, slip detection.
module lrb_lane_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_vld,
   input  logic              in_start,
   input  logic [DATA_W-1:0] in_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] head_data,
   output logic              started,
   output logic              slip
);
   localparam int PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
   localparam int CNT_W = lrb_pkg::cnt_w(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp_q, rp_q, wp_nx, rp_nx;
   logic [CNT_W-1:0]  cnt_q;
   logic              started_q, slip_q;

   logic accept, full, empty, do_wr, do_rd, wr_drop, rd_miss;

   assign accept  = in_vld && (started_q || in_start);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_wr   = accept && (!full || rd_en);
   assign do_rd   = rd_en && !empty;
   assign wr_drop = accept && full && !rd_en;
   assign rd_miss = rd_en && empty;

   generate
      if (lrb_pkg::is_pow2(DEPTH)) begin : g_wrap_free
         assign wp_nx = wp_q + PTR_W'(1);
         assign rp_nx = rp_q + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wp_nx = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
         assign rp_nx = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr && !clr) begin
         mem[wp_q] <= in_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q      <= '0;
         rp_q      <= '0;
         cnt_q     <= '0;
         started_q <= 1'b0;
         slip_q    <= 1'b0;
      end else if (clr) begin
         wp_q      <= '0;
         rp_q      <= '0;
         cnt_q     <= '0;
         started_q <= 1'b0;
         slip_q    <= 1'b0;
      end else begin
         if (do_wr) begin
            wp_q      <= wp_nx;
            started_q <= 1'b1;
         end
         if (do_rd) begin
            rp_q <= rp_nx;
         end
         unique case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
         if (wr_drop || rd_miss) begin
            slip_q <= 1'b1;
         end
      end
   end

   assign head_data = mem[rp_q];
   assign started   = started_q;
   assign slip      = slip_q;

endmodule

// File: rtl/lrb_release_ctrl.sv
// Decides the common release tick and drives lockstep reads.
module lrb_release_ctrl #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             frame_tick,
   input  logic             rls_point,
   input  logic [LANES-1:0] lane_started,
   output logic             rd_en,
   output logic             running,
   output logic [LANES-1:0] late
);
   lrb_pkg::rls_state_e state_q;
   logic [LANES-1:0]    late_q;
   logic                all_in, any_in, go, miss;

   assign all_in = &lane_started;
   assign any_in = |lane_started;
   assign go     = rls_point && (state_q == lrb_pkg::RLS_WAIT) && all_in;
   assign miss   = rls_point && (state_q == lrb_pkg::RLS_WAIT) && any_in && !all_in;
   assign rd_en  = frame_tick && ((state_q == lrb_pkg::RLS_RUN) || go);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= lrb_pkg::RLS_WAIT;
         late_q  <= '0;
      end else if (clr) begin
         state_q <= lrb_pkg::RLS_WAIT;
         late_q  <= '0;
      end else begin
         if (go) begin
            state_q <= lrb_pkg::RLS_RUN;
         end
         if (miss) begin
            late_q <= late_q | ~lane_started;
         end
      end
   end

   assign running = (state_q == lrb_pkg::RLS_RUN);
   assign late    = late_q;

endmodule

// File: rtl/lane_release_buffer.sv
module lane_release_buffer #(
   parameter int LANES         = 4,
   parameter int DATA_W        = 8,
   parameter int FRAMES_PER_MF = 8,
   parameter int FIFO_DEPTH    = 16,
   parameter int RBD_W         = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    resync,
   input  logic                    frame_tick,
   input  logic                    mf_edge,
   input  logic [RBD_W-1:0]        rbd,
   input  logic [LANES-1:0]        lane_vld,
   input  logic [LANES-1:0]        lane_start,
   input  logic [LANES*DATA_W-1:0] lane_data,
   output logic                    out_vld,
   output logic [LANES*DATA_W-1:0] out_data,
   output logic [LANES-1:0]        lane_late,
   output logic [LANES-1:0]        lane_slip
);
   localparam int BUS_W = LANES * DATA_W;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (FRAMES_PER_MF < 2) begin : g_bad_mf
         $error("FRAMES_PER_MF must be at least 2");
      end
      if (FIFO_DEPTH < FRAMES_PER_MF) begin : g_bad_depth
         $error("FIFO_DEPTH must hold a full multiframe");
      end
      if (RBD_W < $clog2(FRAMES_PER_MF + 1)) begin : g_bad_rbd
         $error("RBD_W too narrow for FRAMES_PER_MF");
      end
   endgenerate

   logic             rls_point;
   logic             rd_en;
   logic             rls_run;
   logic [LANES-1:0] started_w;
   logic [LANES-1:0] slip_w;
   logic [LANES-1:0] late_w;
   logic [BUS_W-1:0] head_flat;

   lrb_mf_timer #(
      .FRAMES_PER_MF(FRAMES_PER_MF),
      .RBD_W        (RBD_W)
   ) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_tick(frame_tick),
      .mf_edge   (mf_edge),
      .rbd       (rbd),
      .rls_point (rls_point)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         lrb_lane_fifo #(
            .DATA_W(DATA_W),
            .DEPTH (FIFO_DEPTH)
         ) fifo_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (resync),
            .in_vld   (lane_vld[g]),
            .in_start (lane_start[g]),
            .in_data  (lane_data[g*DATA_W +: DATA_W]),
            .rd_en    (rd_en),
            .head_data(head_flat[g*DATA_W +: DATA_W]),
            .started  (started_w[g]),
            .slip     (slip_w[g])
         );
      end
   endgenerate

   lrb_release_ctrl #(
      .LANES(LANES)
   ) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (resync),
      .frame_tick  (frame_tick),
      .rls_point   (rls_point),
      .lane_started(started_w),
      .rd_en       (rd_en),
      .running     (rls_run),
      .late        (late_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else if (resync) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else begin
         out_vld <= rd_en;
         if (rd_en) begin
            out_data <= head_flat;
         end
      end
   end

   assign lane_late = late_w;
   assign lane_slip = slip_w;

endmodule

// File: rtl/lane_release_buffer_chk.sv
module lane_release_buffer_chk #(
   parameter int LANES  = 4,
   parameter int DATA_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    resync,
   input logic                    frame_tick,
   input logic                    out_vld,
   input logic [LANES*DATA_W-1:0] out_data,
   input logic [LANES-1:0]        lane_late,
   input logic [LANES-1:0]        lane_slip,
   input logic                    released
);

   // R1
   resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> (!out_vld && (lane_late == '0) && (lane_slip == '0) && (out_data == '0)));

   // R8
   no_tick_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> !out_vld);

   // R8
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_tick && !resync) |=> $stable(out_data));

   // R7
   lockstep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (released && !resync) |=> released);

   // R6
   late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resync |=> ((lane_late & $past(lane_late)) == $past(lane_late)));

   // R6
   late_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_tick && !resync) |=> $stable(lane_late));

   // R9
   slip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resync |=> ((lane_slip & $past(lane_slip)) == $past(lane_slip)));

endmodule

bind lane_release_buffer lane_release_buffer_chk #(
   .LANES (LANES),
   .DATA_W(DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .resync    (resync),
   .frame_tick(frame_tick),
   .out_vld   (out_vld),
   .out_data  (out_data),
   .lane_late (lane_late),
   .lane_slip (lane_slip),
   .released  (rls_run)
);

// File: tb/lane_release_buffer_tb_top.sv
module lane_release_buffer_tb_top;
   localparam int LANES  = 4;
   localparam int DATA_W = 8;
   localparam int K      = 8;
   localparam int DEPTH  = 16;
   localparam int RBD_W  = 4;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    resync = 1'b0;
   logic                    frame_tick = 1'b0;
   logic                    mf_edge = 1'b0;
   logic [RBD_W-1:0]        rbd = '0;
   logic [LANES-1:0]        lane_vld = '0;
   logic [LANES-1:0]        lane_start = '0;
   logic [LANES*DATA_W-1:0] lane_data = '0;
   logic                    out_vld;
   logic [LANES*DATA_W-1:0] out_data;
   logic [LANES-1:0]        lane_late;
   logic [LANES-1:0]        lane_slip;

   int checks = 0;
   int errors = 0;

   always #4ns clk = ~clk;

   lane_release_buffer #(
      .LANES(LANES), .DATA_W(DATA_W), .FRAMES_PER_MF(K),
      .FIFO_DEPTH(DEPTH), .RBD_W(RBD_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .resync(resync), .frame_tick(frame_tick),
      .mf_edge(mf_edge), .rbd(rbd), .lane_vld(lane_vld), .lane_start(lane_start),
      .lane_data(lane_data), .out_vld(out_vld), .out_data(out_data),
      .lane_late(lane_late), .lane_slip(lane_slip)
   );

   // Stimulus: release setting, per-lane arrival frame; expected: first
   // release frame and late mask (bit l for lane l).
   typedef struct packed {
      logic [3:0] rbd;
      logic [4:0] a3, a2, a1, a0;
      logic [4:0] tr;
      logic [3:0] late;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{4'd4,  5'd3, 5'd2, 5'd1, 5'd0, 5'd4,  4'b0000},
      '{4'd2,  5'd1, 5'd3, 5'd0, 5'd0, 5'd10, 4'b0100},
      '{4'd8,  5'd1, 5'd2, 5'd2, 5'd1, 5'd8,  4'b0000},
      '{4'd1,  5'd0, 5'd0, 5'd0, 5'd5, 5'd9,  4'b0001},
      '{4'd12, 5'd3, 5'd3, 5'd3, 5'd3, 5'd8,  4'b0000},
      '{4'd7,  5'd7, 5'd7, 5'd6, 5'd6, 5'd15, 4'b1100},
      '{4'd3,  5'd2, 5'd2, 5'd2, 5'd2, 5'd3,  4'b0000},
      '{4'd3,  5'd2, 5'd2, 5'd2, 5'd3, 5'd11, 4'b0001},
      '{4'd0,  5'd0, 5'd0, 5'd0, 5'd0, 5'd8,  4'b0000}
   };

   function automatic logic [DATA_W-1:0] code(input int l, input int s);
      return DATA_W'((l << 6) | (s & 63));
   endfunction

   function automatic int arr_of(input vec_t v, input int l);
      case (l)
         0:       return int'(v.a0);
         1:       return int'(v.a1);
         2:       return int'(v.a2);
         default: return int'(v.a3);
      endcase
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      frame_tick = 1'b0;
      mf_edge    = 1'b0;
      lane_vld   = '0;
      lane_start = '0;
      lane_data  = '0;
   endtask

   task automatic do_resync();
      idle_inputs();
      resync = 1'b1;
      @(posedge clk); @(negedge clk);
      resync = 1'b0;
      // R1: status cleared by resync
      check(!out_vld && lane_late == '0 && lane_slip == '0 && out_data == '0,
            "R1 resync clear", {out_vld, lane_late, lane_slip}, 64'd0);
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      int  tr;
      bit  oor;
      tr  = int'(v.tr);
      oor = (v.rbd == 4'd0) || (int'(v.rbd) > K);
      do_resync();
      rbd = v.rbd;
      for (int t = 0; t <= tr + 4; t++) begin
         frame_tick = 1'b1;
         mf_edge    = (t % K == 0);
         for (int l = 0; l < LANES; l++) begin
            lane_vld[l]   = (t >= arr_of(v, l));
            lane_start[l] = (t == arr_of(v, l));
            lane_data[l*DATA_W +: DATA_W] =
               (t >= arr_of(v, l)) ? code(l, t - arr_of(v, l)) : '0;
         end
         @(posedge clk); @(negedge clk);
         // R3 R5 (R4 when the setting is out of range)
         check(out_vld == (t >= tr),
               $sformatf("%s vec%0d frame%0d release", oor ? "R4 R3 R5" : "R3 R5", idx, t),
               64'(out_vld), 64'(t >= tr));
         if (t >= tr) begin
            for (int l = 0; l < LANES; l++) begin
               // R7 lockstep alignment
               check(out_data[l*DATA_W +: DATA_W] == code(l, t - tr),
                     $sformatf("R7 vec%0d lane%0d frame%0d", idx, l, t),
                     64'(out_data[l*DATA_W +: DATA_W]), 64'(code(l, t - tr)));
            end
         end
      end
      // R6 late mask
      check(lane_late == v.late, $sformatf("R6 vec%0d late", idx),
            64'(lane_late), 64'(v.late));
      // R9 no slip on a normal run
      check(lane_slip == '0, $sformatf("R9 vec%0d slip", idx),
            64'(lane_slip), 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [LANES*DATA_W-1:0] held;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(!out_vld && out_data == '0 && lane_late == '0 && lane_slip == '0,
            "R1 reset", {out_vld, lane_late, lane_slip}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_vld && lane_late == '0 && lane_slip == '0,
            "R1 after reset", {out_vld, lane_late, lane_slip}, 64'd0);

      for (int i = 0; i < NVEC; i++) begin
         run_vec(VECS[i], i);
      end

      // R8: tick gap after release pops nothing, data held
      run_vec(VECS[0], 100);
      idle_inputs();
      held = out_data;
      for (int c = 0; c < 3; c++) begin
         @(posedge clk); @(negedge clk);
         check(!out_vld, "R8 gap valid", 64'(out_vld), 64'd0);
         check(out_data == held, "R8 gap data", 64'(out_data), 64'(held));
      end
      frame_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      check(out_vld, "R8 R7 resume valid", 64'(out_vld), 64'd1);
      for (int l = 0; l < LANES; l++) begin
         check(out_data[l*DATA_W +: DATA_W] == code(l, 5), "R7 resume data",
               64'(out_data[l*DATA_W +: DATA_W]), 64'(code(l, 5)));
      end
      // R9: lane 3 is empty now; the next pop misses
      @(posedge clk); @(negedge clk);
      check(lane_slip == 4'b1000, "R9 underrun", 64'(lane_slip), 64'(4'b1000));

      // R5 R6 R9: only lane 0 arrives; no release, late mask, overflow
      do_resync();
      rbd = 4'd4;
      for (int t = 0; t <= 18; t++) begin
         frame_tick = 1'b1;
         mf_edge    = (t % K == 0);
         lane_vld   = 4'b0001;
         lane_start = (t == 0) ? 4'b0001 : 4'b0000;
         lane_data  = '0;
         lane_data[DATA_W-1:0] = code(0, t);
         @(posedge clk); @(negedge clk);
         check(!out_vld, "R5 hold release", 64'(out_vld), 64'd0);
      end
      check(lane_late == 4'b1110, "R6 missing lanes", 64'(lane_late), 64'(4'b1110));
      check(lane_slip == 4'b0001, "R9 overflow", 64'(lane_slip), 64'(4'b0001));
      // R1: resync wipes the flags
      do_resync();

      // R2: valid frames before the start marker are dropped
      rbd = 4'd4;
      for (int t = 0; t <= 5; t++) begin
         frame_tick = 1'b1;
         mf_edge    = (t % K == 0);
         lane_vld   = '1;
         lane_start = (t == 2) ? '1 : '0;
         for (int l = 0; l < LANES; l++) begin
            lane_data[l*DATA_W +: DATA_W] = (t < 2) ? code(l, 60) : code(l, t - 2);
         end
         @(posedge clk); @(negedge clk);
         check(out_vld == (t >= 4), "R2 R5 start marker release",
               64'(out_vld), 64'(t >= 4));
         if (t >= 4) begin
            for (int l = 0; l < LANES; l++) begin
               check(out_data[l*DATA_W +: DATA_W] == code(l, t - 4), "R2 first kept frame",
                     64'(out_data[l*DATA_W +: DATA_W]), 64'(code(l, t - 4)));
            end
         end
      end
      idle_inputs();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule